// File: doc/BRIEF.md
# Register-Register Integer ALU with Barrel Shifter

This block is the integer execution stage for register-register instructions. Each cycle it takes an 8-bit opcode and two register operands. It returns the destination value and a destination write strobe in the same cycle. One barrel shifter serves all three shift kinds, and the adder path serves both subtract and signed compare.

A 2-bit condition code is kept in a register that later conditional branches read. Each legal instruction loads the register on the next rising clock edge. An opcode outside the map raises a flag, writes nothing and leaves the condition code as it was. Compare changes only the condition code.

Top module: `rr_exec_alu`

## Requirements
- R1: Opcodes 0x14, 0x16 and 0x17 give the bitwise AND, OR and XOR of `rs_a` and `rs_b` on `result`, with `rd_we` high.
- R2: Opcode 0x1B gives `rs_a - rs_b` modulo 2^XLEN with `rd_we` high. The condition code becomes 3 on signed overflow. Otherwise it becomes 0 for a zero difference, 1 for a negative one and 2 for a positive one.
- R3: Opcode 0x19 compares the operands as signed values and sets the condition code to 0 when they are equal, 1 when `rs_a` is less and 2 when `rs_a` is greater.
- R4: Compare (0x19) keeps `rd_we` low and drives `result` to zero.
- R5: After AND, OR or XOR the condition code is 0 when the result is zero and 1 otherwise.
- R6: Opcode 0x88 is a logical right shift and 0x89 a logical left shift of `rs_a`. Vacated bits are zero, `rd_we` is high, and the amount is bits [5:0] of `rs_b`, so the higher bits of `rs_b` have no effect.
- R7: A logical shift by an amount of 32 to 63 gives zero.
- R8: Opcode 0x8A is an arithmetic right shift that fills vacated bits with bit 31 of `rs_a`. An amount of 32 to 63 gives 32 copies of that bit.
- R9: After any shift the condition code is 0 when the result is zero, 1 when bit 31 of the result is set and 2 otherwise.
- R10: Any opcode other than the eight above sets `bad_op` high, keeps `rd_we` low, drives `result` to zero and leaves the condition code unchanged.
- R11: `result`, `rd_we` and `bad_op` follow the inputs within the same cycle. `cc` takes its new value at the next rising clock edge and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the condition-code register |
| rst_n | input | 1 | Active-low asynchronous reset |
| opcode | input | 8 | Instruction opcode |
| rs_a | input | XLEN | First register operand |
| rs_b | input | XLEN | Second register operand or shift amount |
| result | output | XLEN | Value for the destination register |
| rd_we | output | 1 | Destination write strobe |
| cc | output | 2 | Registered condition code |
| bad_op | output | 1 | Opcode outside the map |

## Verification
The assertions assume that `opcode`, `rs_a` and `rs_b` are settled before each rising edge and stay constant through it. The combinational outputs are checked against them there. The bench changes inputs only on falling edges. It reads the combinational outputs shortly after that and reads `cc` shortly after the following rising edge, so every sample falls between two edges. Operands come from a grid of sign and overflow boundary values. Shifts sweep every amount from 0 to 63, with junk in the upper bits of `rs_b`.

// File: rtl/rr_alu_pkg.sv
package rr_alu_pkg;

   typedef enum logic [7:0] {
      OPC_AND = 8'h14,
      OPC_OR  = 8'h16,
      OPC_XOR = 8'h17,
      OPC_CMP = 8'h19,
      OPC_SUB = 8'h1B,
      OPC_SRL = 8'h88,
      OPC_SLL = 8'h89,
      OPC_SRA = 8'h8A
   } opc_e;

   typedef enum logic [1:0] {
      CC_ZERO = 2'd0,
      CC_LOW  = 2'd1,
      CC_HIGH = 2'd2,
      CC_OVF  = 2'd3
   } cc_e;

   typedef enum logic [2:0] {
      FN_LOGIC,
      FN_SUB,
      FN_CMP,
      FN_SHIFT,
      FN_NONE
   } fn_e;

   typedef enum logic [1:0] {
      LG_AND,
      LG_OR,
      LG_XOR
   } lg_e;

   typedef enum logic [1:0] {
      SH_RL,
      SH_LL,
      SH_RA
   } sh_e;

   typedef struct packed {
      fn_e  fn;
      lg_e  lg;
      sh_e  sh;
      logic we;
      logic bad;
   } ctl_t;

endpackage

// File: rtl/rr_alu_decode.sv
module rr_alu_decode
   import rr_alu_pkg::*;
(
   input  logic [7:0] opcode,
   output ctl_t       ctl
);

   always_comb begin
      ctl.fn  = FN_NONE;
      ctl.lg  = LG_AND;
      ctl.sh  = SH_RL;
      ctl.we  = 1'b0;
      ctl.bad = 1'b0;
      case (opcode)
         OPC_AND: begin ctl.fn = FN_LOGIC; ctl.lg = LG_AND; ctl.we = 1'b1; end
         OPC_OR:  begin ctl.fn = FN_LOGIC; ctl.lg = LG_OR;  ctl.we = 1'b1; end
         OPC_XOR: begin ctl.fn = FN_LOGIC; ctl.lg = LG_XOR; ctl.we = 1'b1; end
         OPC_SUB: begin ctl.fn = FN_SUB;   ctl.we = 1'b1; end
         OPC_CMP: begin ctl.fn = FN_CMP;   ctl.we = 1'b0; end
         OPC_SRL: begin ctl.fn = FN_SHIFT; ctl.sh = SH_RL;  ctl.we = 1'b1; end
         OPC_SLL: begin ctl.fn = FN_SHIFT; ctl.sh = SH_LL;  ctl.we = 1'b1; end
         OPC_SRA: begin ctl.fn = FN_SHIFT; ctl.sh = SH_RA;  ctl.we = 1'b1; end
         default: ctl.bad = 1'b1;
      endcase
   end

endmodule

// File: rtl/rr_alu_arith.sv
module rr_alu_arith
   import rr_alu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] diff,
   output cc_e          cc_sub,
   output cc_e          cc_cmp
);

   logic ovf;
   logic less;

   always_comb begin
      diff = a - b;
      ovf  = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
      less = diff[W-1] ^ ovf;

      if (ovf)
         cc_sub = CC_OVF;
      else if (diff == '0)
         cc_sub = CC_ZERO;
      else if (diff[W-1])
         cc_sub = CC_LOW;
      else
         cc_sub = CC_HIGH;

      if (a == b)
         cc_cmp = CC_ZERO;
      else if (less)
         cc_cmp = CC_LOW;
      else
         cc_cmp = CC_HIGH;
   end

endmodule

// File: rtl/rr_alu_logic.sv
module rr_alu_logic
   import rr_alu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  lg_e          lg,
   output logic [W-1:0] y,
   output cc_e          cc_y
);

   always_comb begin
      case (lg)
         LG_OR:   y = a | b;
         LG_XOR:  y = a ^ b;
         default: y = a & b;
      endcase
      cc_y = (y == '0) ? CC_ZERO : CC_LOW;
   end

endmodule

// File: rtl/rr_alu_shift.sv
module rr_alu_shift
   import rr_alu_pkg::*;
#(
   parameter int W      = 32,
   parameter int AW     = 6,
   parameter bit STAGED = 1'b1
) (
   input  logic [W-1:0]  x,
   input  logic [AW-1:0] amt,
   input  sh_e           sh,
   output logic [W-1:0]  y
);

   localparam int LW = $clog2(W);

   logic fill;
   logic over;

   assign fill = (sh == SH_RA) & x[W-1];
   assign over = |amt[AW-1:LW];

   generate
      if (STAGED) begin : g_staged
         logic          left;
         logic [W-1:0]  xin;
         logic [W-1:0]  rsh;
         logic [W-1:0]  st [LW+1];

         assign left = (sh == SH_LL);

         always_comb begin
            for (int i = 0; i < W; i++)
               xin[i] = left ? x[W-1-i] : x[i];
         end

         assign st[0] = xin;

         for (genvar g = 0; g < LW; g++) begin : g_stage
            localparam int D = 1 << g;
            assign st[g+1] = amt[g] ? {{D{fill}}, st[g][W-1:D]} : st[g];
         end

         assign rsh = over ? {W{fill}} : st[LW];

         always_comb begin
            for (int i = 0; i < W; i++)
               y[i] = left ? rsh[W-1-i] : rsh[i];
         end
      end else begin : g_flat
         always_comb begin
            if (over)
               y = {W{fill}};
            else begin
               case (sh)
                  SH_LL:   y = x << amt[LW-1:0];
                  SH_RA:   y = W'($signed(x) >>> amt[LW-1:0]);
                  default: y = x >> amt[LW-1:0];
               endcase
            end
         end
      end
   endgenerate

endmodule

// File: rtl/rr_exec_alu.sv
module rr_exec_alu
   import rr_alu_pkg::*;
#(
   parameter int XLEN         = 32,
   parameter int SHAMT_W      = 6,
   parameter bit STAGED_SHIFT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [7:0]      opcode,
   input  logic [XLEN-1:0] rs_a,
   input  logic [XLEN-1:0] rs_b,
   output logic [XLEN-1:0] result,
   output logic            rd_we,
   output logic [1:0]      cc,
   output logic            bad_op
);

   localparam int               LW   = $clog2(XLEN);
   localparam logic [SHAMT_W:0] XLIM = (SHAMT_W + 1)'(XLEN);

   generate
      if (XLEN < 8 || (XLEN & (XLEN - 1)) != 0) begin : g_chk_xlen
         $error("XLEN must be a power of two of at least 8");
      end
      if (SHAMT_W <= LW) begin : g_chk_shw
         $error("SHAMT_W must exceed log2(XLEN)");
      end
   endgenerate

   ctl_t            ctl;
   logic [XLEN-1:0] diff;
   logic [XLEN-1:0] lg_y;
   logic [XLEN-1:0] sh_y;
   cc_e             cc_sub;
   cc_e             cc_cmp;
   cc_e             cc_lg;
   cc_e             cc_sh;
   cc_e             cc_nxt;
   cc_e             cc_q;

   rr_alu_decode u_dec (
      .opcode (opcode),
      .ctl    (ctl)
   );

   rr_alu_arith #(.W(XLEN)) u_arith (
      .a      (rs_a),
      .b      (rs_b),
      .diff   (diff),
      .cc_sub (cc_sub),
      .cc_cmp (cc_cmp)
   );

   rr_alu_logic #(.W(XLEN)) u_logic (
      .a    (rs_a),
      .b    (rs_b),
      .lg   (ctl.lg),
      .y    (lg_y),
      .cc_y (cc_lg)
   );

   rr_alu_shift #(.W(XLEN), .AW(SHAMT_W), .STAGED(STAGED_SHIFT)) u_shift (
      .x   (rs_a),
      .amt (rs_b[SHAMT_W-1:0]),
      .sh  (ctl.sh),
      .y   (sh_y)
   );

   always_comb begin
      if (sh_y == '0)
         cc_sh = CC_ZERO;
      else if (sh_y[XLEN-1])
         cc_sh = CC_LOW;
      else
         cc_sh = CC_HIGH;
   end

   always_comb begin
      result = '0;
      cc_nxt = cc_q;
      case (ctl.fn)
         FN_LOGIC: begin result = lg_y; cc_nxt = cc_lg;  end
         FN_SUB:   begin result = diff; cc_nxt = cc_sub; end
         FN_CMP:   begin cc_nxt = cc_cmp; end
         FN_SHIFT: begin result = sh_y; cc_nxt = cc_sh;  end
         default:  begin end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cc_q <= CC_ZERO;
      else if (!ctl.bad)
         cc_q <= cc_nxt;
   end

   assign rd_we  = ctl.we;
   assign bad_op = ctl.bad;
   assign cc     = cc_q;

   a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == OPC_CMP) |-> (!rd_we && result == '0));

   a_r10_bad_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      bad_op |-> !rd_we);

   a_r10_bad_keeps_cc: assert property (@(posedge clk) disable iff (!rst_n)
      bad_op |=> $stable(cc));

   a_r2_ovf_from_sub: assert property (@(posedge clk) disable iff (!rst_n)
      (cc == CC_OVF && !$stable(cc)) |-> ($past(opcode) == OPC_SUB));

   a_r5_logic_cc_range: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == OPC_AND || opcode == OPC_OR || opcode == OPC_XOR) |=> (cc[1] == 1'b0));

   a_r8_sra_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == OPC_SRA && {1'b0, rs_b[SHAMT_W-1:0]} >= XLIM)
         |-> (result == {XLEN{rs_a[XLEN-1]}}));

   a_r7_logic_shift_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      ((opcode == OPC_SRL || opcode == OPC_SLL) && {1'b0, rs_b[SHAMT_W-1:0]} >= XLIM)
         |-> (result == '0));

endmodule

// File: tb/rr_exec_alu_tb.sv
module rr_exec_alu_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  opcode = 8'h00;
   logic [31:0] rs_a = '0;
   logic [31:0] rs_b = '0;
   logic [31:0] result;
   logic        rd_we;
   logic [1:0]  cc;
   logic        bad_op;

   int   n_chk = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;
   logic [1:0] cc_exp = 2'd0;

   always #2 clk = ~clk;

   rr_exec_alu u_dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .opcode (opcode),
      .rs_a   (rs_a),
      .rs_b   (rs_b),
      .result (result),
      .rd_we  (rd_we),
      .cc     (cc),
      .bad_op (bad_op)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s op=%h a=%h b=%h act=%h exp=%h", tag, opcode, rs_a, rs_b, act, exp);
      end
   endtask

   function automatic logic [1:0] sign_cc(input logic [31:0] v);
      if (v == 0) return 2'd0;
      if (v[31])  return 2'd1;
      return 2'd2;
   endfunction

   task automatic run(input logic [7:0] op, input logic [31:0] a, input logic [31:0] b);
      logic [31:0] er;
      logic        ewe;
      logic        ebad;
      logic [1:0]  ecc;
      string       tg;
      longint      sd;
      int          amt;
      @(negedge clk);
      opcode = op; rs_a = a; rs_b = b;
      #1;
      amt  = int'(b[5:0]);
      er   = '0; ewe = 1'b1; ebad = 1'b0; ecc = cc_exp; tg = "R10";
      case (op)
         8'h14: begin er = a & b; ecc = (er == 0) ? 2'd0 : 2'd1; tg = "R1/R5"; end
         8'h16: begin er = a | b; ecc = (er == 0) ? 2'd0 : 2'd1; tg = "R1/R5"; end
         8'h17: begin er = a ^ b; ecc = (er == 0) ? 2'd0 : 2'd1; tg = "R1/R5"; end
         8'h1B: begin
            sd = longint'($signed(a)) - longint'($signed(b));
            er = a - b;
            if (sd > 64'sd2147483647 || sd < -64'sd2147483648) ecc = 2'd3;
            else ecc = sign_cc(er);
            tg = "R2";
         end
         8'h19: begin
            ewe = 1'b0;
            if ($signed(a) == $signed(b))     ecc = 2'd0;
            else if ($signed(a) < $signed(b)) ecc = 2'd1;
            else                              ecc = 2'd2;
            tg = "R3/R4";
         end
         8'h88: begin er = (amt >= 32) ? 32'h0 : (a >> amt); ecc = sign_cc(er); tg = "R6/R7/R9"; end
         8'h89: begin er = (amt >= 32) ? 32'h0 : (a << amt); ecc = sign_cc(er); tg = "R6/R7/R9"; end
         8'h8A: begin
            if (amt >= 32) er = {32{a[31]}};
            else begin
               er = a >> amt;
               for (int k = 0; k < amt; k++) er[31-k] = a[31];
            end
            ecc = sign_cc(er); tg = "R8/R9";
         end
         default: begin ewe = 1'b0; ebad = 1'b1; end
      endcase
      chk({tg, " result"}, result, er);
      chk({tg, " rd_we R11"}, {31'b0, rd_we}, {31'b0, ewe});
      chk({tg, " bad_op R10"}, {31'b0, bad_op}, {31'b0, ebad});
      @(posedge clk);
      #1;
      cc_exp = ecc;
      chk({tg, " cc R11"}, {30'b0, cc}, {30'b0, cc_exp});
   endtask

   localparam logic [31:0] VALS [8] = '{
      32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
      32'h8000_0000, 32'h1234_5678, 32'hF0F0_0F0F, 32'h8000_0001
   };
   localparam logic [7:0] OPS [8] = '{
      8'h14, 8'h16, 8'h17, 8'h19, 8'h1B, 8'h88, 8'h89, 8'h8A
   };

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R11 reset cc", {30'b0, cc}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int o = 0; o < 8; o++)
         for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
               run(OPS[o], VALS[i], VALS[j]);

      for (int s = 0; s < 64; s++) begin
         run(8'h88, 32'h8765_4321, {26'h2AB_CDEF, 6'(s)});
         run(8'h89, 32'h8765_4321, {26'h155_0000, 6'(s)});
         run(8'h8A, 32'h8765_4321, {26'h3FF_FFFF, 6'(s)});
         run(8'h8A, 32'h4765_4321, {26'h000_0001, 6'(s)});
      end

      for (int o = 0; o < 256; o++) begin
         if (o == 'h14 || o == 'h16 || o == 'h17 || o == 'h19 ||
             o == 'h1B || o == 'h88 || o == 'h89 || o == 'h8A)
            continue;
         if (o % 4 == 0)
            run(8'h1B, 32'h8000_0000, 32'h0000_0001);
         else if (o % 4 == 1)
            run(8'h19, 32'h0000_0005, 32'h0000_0003);
         run(8'(o), 32'hFFFF_FFFF, 32'h0000_0001);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule